// File: doc/BRIEF.md
# Streaming Pattern Recognizer

This block watches a stream of symbols drawn from a four-letter alphabet {a, b, c, d} and decides, one symbol at a time, whether everything received since the last clear spells a word of the fixed language a? b? c+ (a*|b*) d (b|c)*. Each symbol arrives as a 2-bit code qualified by a valid strobe. There is no framing and no separator symbol; the caller marks the start of a new word with a synchronous clear.

Two registered flags report the verdict on the prefix seen so far. `match` says the prefix is a complete word of the language. `dead` says no continuation can ever make it a word, so the caller can give up on the current attempt early. The choice between an a-run and a b-run after the c-run is settled by the first a or b that arrives after the c's; a mix of the two is rejected.

Top module: `seq_lang_recognizer`

## Requirements
- R1: After a synchronous reset, `match` and `dead` are both 0 (the empty prefix), and they stay so until a symbol is accepted.
- R2: Symbols are encoded a=2'b00, b=2'b01, c=2'b10, d=2'b11 and are taken only on a clock edge where `sym_valid` is 1; with `sym_valid` 0 and `clear` 0, `match` and `dead` hold their values.
- R3: `match` is 1 in the cycle after the edge that accepts a symbol completing a word of the language, e.g. "cd", "abcd", "ccaad", "cbbd".
- R4: Before the c-run, at most one a and then at most one b may appear; a second a, a second b, or a b followed by an a makes `dead` 1.
- R5: At least one c must precede any d and any a-run or b-run; a d received before any c makes `dead` 1.
- R6: After the c-run, either only a's or only b's may come before the d; mixing a and b, or a c after that run, makes `dead` 1.
- R7: After the d, each further b or c keeps `match` at 1; an a or a second d makes `dead` 1 and `match` 0.
- R8: Once `dead` is 1 it stays 1, with `match` 0, for every further symbol until `clear` or reset; `match` and `dead` are never both 1.
- R9: `clear` is synchronous and returns the recognizer to the empty prefix (`match` 0, `dead` 0) one cycle later; it takes priority over a symbol presented on the same edge, which is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous restart of the word, priority over symbols |
| sym_valid | input | 1 | Qualifies `sym` on this edge |
| sym | input | 2 | Symbol code: a=00, b=01, c=10, d=11 |
| match | output | 1 | Registered: prefix is a complete word |
| dead | output | 1 | Registered: prefix can no longer become a word |

## Verification
The bench targets the a/b decision after the c-run: a design that keeps one shared state for both runs would accept "cabd" instead of killing it at the b. It also drives d straight from the start and after an a/b prefix with no c, which a machine that treats c+ as c* would accept, and a second a or d after the tail, which a design with a too permissive tail would keep matching. Clear arriving together with a valid d checks that the discarded symbol does not push the fresh word into the dead state, and idle cycles after a match check that an unqualified symbol code changes nothing.

// File: rtl/recog_pkg.sv
package recog_pkg;

  localparam int SYM_W = 2;
  localparam int ST_W  = 3;

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_A = 2'b00;
  localparam sym_t SYM_B = 2'b01;
  localparam sym_t SYM_C = 2'b10;
  localparam sym_t SYM_D = 2'b11;

  // Recognizer positions inside the language
  typedef enum logic [ST_W-1:0] {
    ST_START = 3'd0, // empty prefix
    ST_PRE_A = 3'd1, // optional leading a taken
    ST_PRE_B = 3'd2, // optional b taken
    ST_CRUN  = 3'd3, // inside the mandatory c run
    ST_ARUN  = 3'd4, // a run chosen after the c run
    ST_BRUN  = 3'd5, // b run chosen after the c run
    ST_TAIL  = 3'd6, // d seen, accepting, b/c loop
    ST_DEAD  = 3'd7  // absorbing reject
  } state_t;

endpackage

// File: rtl/recog_next.sv
module recog_next
  import recog_pkg::*;
(
  input  state_t cur,
  input  logic   clear,
  input  logic   vld,
  input  sym_t   sym,
  output state_t nxt
);

  state_t step;

  always_comb begin
    step = ST_DEAD;
    unique case (cur)
      ST_START: begin
        unique case (sym)
          SYM_A:   step = ST_PRE_A;
          SYM_B:   step = ST_PRE_B;
          SYM_C:   step = ST_CRUN;
          default: step = ST_DEAD;
        endcase
      end
      ST_PRE_A: begin
        unique case (sym)
          SYM_B:   step = ST_PRE_B;
          SYM_C:   step = ST_CRUN;
          default: step = ST_DEAD;
        endcase
      end
      ST_PRE_B: step = (sym == SYM_C) ? ST_CRUN : ST_DEAD;
      ST_CRUN: begin
        unique case (sym)
          SYM_A:   step = ST_ARUN;
          SYM_B:   step = ST_BRUN;
          SYM_C:   step = ST_CRUN;
          default: step = ST_TAIL;
        endcase
      end
      ST_ARUN: begin
        unique case (sym)
          SYM_A:   step = ST_ARUN;
          SYM_D:   step = ST_TAIL;
          default: step = ST_DEAD;
        endcase
      end
      ST_BRUN: begin
        unique case (sym)
          SYM_B:   step = ST_BRUN;
          SYM_D:   step = ST_TAIL;
          default: step = ST_DEAD;
        endcase
      end
      ST_TAIL: step = (sym == SYM_B || sym == SYM_C) ? ST_TAIL : ST_DEAD;
      default: step = ST_DEAD;
    endcase
  end

  always_comb begin
    if (clear)    nxt = ST_START;
    else if (vld) nxt = step;
    else          nxt = cur;
  end

endmodule

// File: rtl/recog_state_reg.sv
module recog_state_reg
  import recog_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t nxt,
  output state_t cur,
  output logic   match_q,
  output logic   dead_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= ST_START;
      match_q <= 1'b0;
      dead_q  <= 1'b0;
    end else begin
      cur     <= nxt;
      match_q <= (nxt == ST_TAIL);
      dead_q  <= (nxt == ST_DEAD);
    end
  end

endmodule

// File: rtl/seq_lang_recognizer.sv
module seq_lang_recognizer
  import recog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             match,
  output logic             dead
);

  state_t cur_st;
  state_t nxt_st;

  recog_next u_next (
    .cur   (cur_st),
    .clear (clear),
    .vld   (sym_valid),
    .sym   (sym),
    .nxt   (nxt_st)
  );

  recog_state_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt_st),
    .cur     (cur_st),
    .match_q (match),
    .dead_q  (dead)
  );

endmodule

// File: rtl/recog_checker.sv
module recog_checker (
  input logic       clk,
  input logic       rst,
  input logic       clear,
  input logic       sym_valid,
  input logic [1:0] sym,
  input logic       match,
  input logic       dead
);

  a_r8_dead_absorbing: assert property (@(posedge clk) disable iff (rst)
    (dead && !clear) |=> dead);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(match && dead));

  a_r9_clear_empty: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!match && !dead));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !sym_valid) |=> ($stable(match) && $stable(dead)));

  a_r7_tail_kill: assert property (@(posedge clk) disable iff (rst)
    (match && !clear && sym_valid && (sym == 2'b00 || sym == 2'b11)) |=> dead);

  a_r7_tail_keep: assert property (@(posedge clk) disable iff (rst)
    (match && !clear && sym_valid && (sym == 2'b01 || sym == 2'b10)) |=> match);

endmodule

bind seq_lang_recognizer recog_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .sym_valid (sym_valid),
  .sym       (sym),
  .match     (match),
  .dead      (dead)
);

// File: tb/tb_seq_lang_recognizer.sv
module tb_seq_lang_recognizer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym = 2'b00;
  logic       match;
  logic       dead;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  seq_lang_recognizer dut (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .sym_valid (sym_valid),
    .sym       (sym),
    .match     (match),
    .dead      (dead)
  );

  // {req[3:0], clear, valid, sym[1:0], exp_match, exp_dead}
  // a=00 b=01 c=10 d=11
  localparam int NV = 49;
  localparam logic [9:0] VEC [NV] = '{
    {4'd9, 6'b1_0_00_0_0},                          // R9 clear
    {4'd3, 6'b0_1_00_0_0}, {4'd3, 6'b0_1_01_0_0},   // R3 a b
    {4'd3, 6'b0_1_10_0_0}, {4'd3, 6'b0_1_11_1_0},   // R3 c d -> abcd
    {4'd7, 6'b0_1_01_1_0}, {4'd7, 6'b0_1_10_1_0},   // R7 tail b c
    {4'd7, 6'b0_1_00_0_1}, {4'd8, 6'b0_1_10_0_1},   // R7 a kills, R8 stays dead
    {4'd9, 6'b1_0_00_0_0},
    {4'd3, 6'b0_1_10_0_0}, {4'd3, 6'b0_1_10_0_0},   // R3 ccaad
    {4'd3, 6'b0_1_00_0_0}, {4'd3, 6'b0_1_00_0_0},
    {4'd3, 6'b0_1_11_1_0},
    {4'd9, 6'b1_0_00_0_0},
    {4'd3, 6'b0_1_10_0_0}, {4'd3, 6'b0_1_01_0_0},   // R3 cbbd
    {4'd3, 6'b0_1_01_0_0}, {4'd3, 6'b0_1_11_1_0},
    {4'd7, 6'b0_1_01_1_0}, {4'd7, 6'b0_1_11_0_1},   // R7 second d kills
    {4'd9, 6'b1_0_00_0_0},
    {4'd6, 6'b0_1_10_0_0}, {4'd6, 6'b0_1_00_0_0},   // R6 cab mixes runs
    {4'd6, 6'b0_1_01_0_1},
    {4'd9, 6'b1_0_00_0_0},
    {4'd5, 6'b0_1_11_0_1},                          // R5 d first
    {4'd9, 6'b1_0_00_0_0},
    {4'd4, 6'b0_1_01_0_0}, {4'd4, 6'b0_1_00_0_1},   // R4 b then a
    {4'd9, 6'b1_0_00_0_0},
    {4'd4, 6'b0_1_00_0_0}, {4'd4, 6'b0_1_00_0_1},   // R4 aa
    {4'd9, 6'b1_0_00_0_0},
    {4'd3, 6'b0_1_10_0_0}, {4'd3, 6'b0_1_11_1_0},   // R3 cd
    {4'd2, 6'b0_0_00_1_0},                          // R2 idle a ignored
    {4'd9, 6'b1_1_11_0_0},                          // R9 clear beats d
    {4'd6, 6'b0_1_10_0_0}, {4'd6, 6'b0_1_00_0_0},   // R6 cac
    {4'd6, 6'b0_1_10_0_1},
    {4'd9, 6'b1_0_00_0_0},
    {4'd3, 6'b0_1_00_0_0}, {4'd3, 6'b0_1_10_0_0},   // R3 accbdc
    {4'd3, 6'b0_1_10_0_0}, {4'd3, 6'b0_1_01_0_0},
    {4'd3, 6'b0_1_11_1_0}, {4'd7, 6'b0_1_10_1_0}
  };

  task automatic step(input logic c, input logic v, input logic [1:0] s);
    clear     = c;
    sym_valid = v;
    sym       = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic em, input logic ed);
    n_checks++;
    if (match !== em || dead !== ed) begin
      n_fail++;
      $display("FAIL %s: match/dead = %b/%b, expected %b/%b", req, match, dead, em, ed);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 1'b0, 1'b0);
    step(1'b0, 1'b0, 2'b11);
    check("R1 idle after reset", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3:2]);
      check($sformatf("R%0d vector %0d", VEC[i][9:6], i), VEC[i][1], VEC[i][0]);
    end

    // R8: dead survives many symbols
    step(1'b1, 1'b0, 2'b00);
    step(1'b0, 1'b1, 2'b11);
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 2'(k % 4));
    check("R8 dead absorbing", 1'b0, 1'b1);

    // R1: reset recovers from dead
    rst = 1'b1;
    step(1'b0, 1'b0, 2'b00);
    rst = 1'b0;
    check("R1 reset clears dead", 1'b0, 1'b0);
    step(1'b0, 1'b1, 2'b10);
    step(1'b0, 1'b1, 2'b11);
    check("R3 cd after reset", 1'b1, 1'b0);

    // R2: idle cycles with every code hold match
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 2'(k));
    check("R2 idle hold", 1'b1, 1'b0);

    // R5: a b d without c
    step(1'b1, 1'b0, 2'b00);
    step(1'b0, 1'b1, 2'b00);
    step(1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b1, 2'b11);
    check("R5 abd rejected", 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule